// File: doc/BRIEF.md
# Energy-to-Frequency Pulse Generator

This block converts a stream of per-sample energy increments into a pulse train whose average rate is proportional to the accumulated energy. On each sample strobe, a 32-bit increment is added to a 32-bit phase accumulator. A carry out of that addition starts an output pulse. The pulse length is a programmable number of coarse ticks. Each coarse tick is eight sample strobes, counted by a fine prescaler.

The most significant bit of the accumulator acts as a blanking window. On any strobe where the updated accumulator has its top bit set, the output is driven low and the countdown counters hold their values. A width value of zero suppresses pulses. The width is captured only when a pulse starts. Between strobes, nothing changes.

Top module: `energy_pulse_gen`

## Requirements
- R1: After `rst_ni` is asserted, `pulse_o` is 0, the accumulator is 0 and both countdown counters are 0.
- R2: On every cycle with `strobe_i` high, `incr_i` is added to the accumulator modulo 2^32. A carry means the true 33-bit sum is at least 2^32.
- R3: On a strobe, if bit 31 of the new accumulator value is 1, `pulse_o` goes low on the next cycle. Both counters hold their values, even if the addition also carried.
- R4: On a strobe that carries with bit 31 of the new value 0 and a non-zero `width_i`, `pulse_o` is 1 on the next cycle. The coarse counter loads `width_i` and the fine counter loads 8. This also restarts a pulse that is already high.
- R5: On a carrying strobe with bit 31 clear and `width_i` equal to 0, `pulse_o` is 0 on the next cycle and no pulse follows.
- R6: On a strobe with no carry and bit 31 clear, the fine counter steps down. When the fine counter is at 1 or 0, it reloads 8 and the coarse counter (if non-zero) decrements. `pulse_o` goes low when the coarse counter reaches 0. With no blanking, a pulse of width W is high for exactly 8*W strobes.
- R7: `width_i` is used only on the strobe that starts a pulse. Later changes do not alter the pulse in progress.
- R8: With `strobe_i` low, the accumulator, both counters and `pulse_o` all hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Sample strobe, one cycle per sample |
| incr_i | input | 32 | Energy increment added per strobe |
| width_i | input | 8 | Pulse width in coarse ticks (0 disables pulses) |
| pulse_o | output | 1 | Calibration pulse output |

## Verification
The hardest case to reach is a full-length pulse. It needs a carry whose result leaves the accumulator's top bit clear, followed by 8*W strobes that neither carry nor set that bit. The bench drives this in two steps. It first computes an increment that lands the sum exactly at 2^32 or 2^32+1. It then applies zero increments, so the accumulator stays small while the countdown runs. A second hard case is a strobe that carries and sets bit 31 at the same time. The bench reaches it by first parking the accumulator at 0xC0000000 and then adding 0xC0000000.

// File: rtl/epg_pkg.sv
package epg_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_BLANK = 2'd1,
    ACT_START = 2'd2,
    ACT_TICK  = 2'd3
  } act_e;
endpackage

// File: rtl/epg_accum.sv
module epg_accum #(
  parameter int ACC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic [ACC_W-1:0] incr_i,
  output logic             carry_o,
  output logic             msb_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  assign sum     = {1'b0, acc_q} + {1'b0, incr_i};
  assign carry_o = sum[ACC_W];
  assign msb_o   = sum[ACC_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       acc_q <= '0;
    else if (strobe_i) acc_q <= sum[ACC_W-1:0];
  end
endmodule

// File: rtl/epg_fine.sv
module epg_fine #(
  parameter int PRESCALE = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic step_i,
  output logic wrap_o
);
  localparam int FINE_W = $clog2(PRESCALE + 1);
  logic [FINE_W-1:0] fine_q;

  // zero after reset behaves as terminal
  assign wrap_o = step_i && (fine_q <= FINE_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 fine_q <= '0;
    else if (load_i || wrap_o)   fine_q <= FINE_W'(PRESCALE);
    else if (step_i)             fine_q <= fine_q - FINE_W'(1);
  end
endmodule

// File: rtl/epg_coarse.sv
module epg_coarse #(
  parameter int WIDTH_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [WIDTH_W-1:0] width_i,
  input  logic               tick_i,
  output logic               expire_o
);
  logic [WIDTH_W-1:0] coarse_q;

  assign expire_o = tick_i && (coarse_q == WIDTH_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          coarse_q <= '0;
    else if (load_i)                      coarse_q <= width_i;
    else if (tick_i && (coarse_q != '0))  coarse_q <= coarse_q - WIDTH_W'(1);
  end
endmodule

// File: rtl/energy_pulse_gen.sv
module energy_pulse_gen #(
  parameter int ACC_W    = 32,
  parameter int WIDTH_W  = 8,
  parameter int PRESCALE = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               strobe_i,
  input  logic [ACC_W-1:0]   incr_i,
  input  logic [WIDTH_W-1:0] width_i,
  output logic               pulse_o
);
  import epg_pkg::*;

  logic carry, msb, wrap, expire, pulse_q;
  act_e act;

  always_comb begin
    if (!strobe_i)  act = ACT_HOLD;
    else if (msb)   act = ACT_BLANK;
    else if (carry) act = ACT_START;
    else            act = ACT_TICK;
  end

  epg_accum #(.ACC_W(ACC_W)) u_accum (
    .clk_i, .rst_ni, .strobe_i, .incr_i,
    .carry_o(carry), .msb_o(msb)
  );

  epg_fine #(.PRESCALE(PRESCALE)) u_fine (
    .clk_i, .rst_ni,
    .load_i(act == ACT_START),
    .step_i(act == ACT_TICK),
    .wrap_o(wrap)
  );

  epg_coarse #(.WIDTH_W(WIDTH_W)) u_coarse (
    .clk_i, .rst_ni,
    .load_i(act == ACT_START),
    .width_i,
    .tick_i(wrap),
    .expire_o(expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= 1'b0;
    else begin
      unique case (act)
        ACT_BLANK: pulse_q <= 1'b0;
        ACT_START: pulse_q <= (width_i != '0);
        ACT_TICK:  if (expire) pulse_q <= 1'b0;
        default:   pulse_q <= pulse_q;
      endcase
    end
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/epg_checker.sv
module epg_checker #(
  parameter int WIDTH_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               strobe_i,
  input logic               carry_i,
  input logic               msb_i,
  input logic [WIDTH_W-1:0] width_i,
  input logic               pulse_i
);
  AST_BLANK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && msb_i |=> !pulse_i); // R3
  AST_CARRY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && carry_i && !msb_i && (width_i != '0) |=> pulse_i); // R4
  AST_RISE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_i) |-> $past(strobe_i && carry_i && (width_i != '0))); // R4
  AST_ZERO_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && carry_i && !msb_i && (width_i == '0) |=> !pulse_i); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(pulse_i)); // R8
endmodule

bind energy_pulse_gen epg_checker #(.WIDTH_W(WIDTH_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(strobe_i),
  .carry_i(carry), .msb_i(msb), .width_i(width_i), .pulse_i(pulse_o)
);

// File: tb/energy_pulse_gen_tb.sv
module energy_pulse_gen_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        strobe_i = 1'b0;
  logic [31:0] incr_i = '0;
  logic [7:0]  width_i = '0;
  logic        pulse_o;

  int n_chk = 0, n_bad = 0;
  logic  exp_q[$];
  string req_q[$];
  string cur_req = "R1";

  logic [31:0] m_acc = '0;
  int          m_fine = 0, m_coarse = 0;
  logic        m_pulse = 1'b0;

  always #5 clk_i = ~clk_i;

  energy_pulse_gen u_dut (.*);

  // driver: applies one cycle of stimulus and predicts pulse_o after the edge
  task automatic step(input logic s, input logic [31:0] inc, input logic [7:0] w);
    logic [32:0] sum;
    @(negedge clk_i);
    strobe_i = s; incr_i = inc; width_i = w;
    if (s) begin
      sum = {1'b0, m_acc} + {1'b0, inc};
      m_acc = sum[31:0];
      if (sum[31]) m_pulse = 1'b0;
      else if (sum[32]) begin
        m_pulse = (w != 0); m_coarse = int'(w); m_fine = 8;
      end else if (m_fine <= 1) begin
        m_fine = 8;
        if (m_coarse != 0) begin
          m_coarse--;
          if (m_coarse == 0) m_pulse = 1'b0;
        end
      end else m_fine--;
    end
    exp_q.push_back(m_pulse);
    req_q.push_back(cur_req);
  endtask

  // starts a pulse with width w via an exact carry that leaves bit 31 clear
  task automatic fire(input logic [7:0] w);
    if (m_acc == 0) step(1'b1, 32'h8000_0000, w);
    if (m_acc == 1) step(1'b1, 32'hFFFF_FFFF, w);
    else            step(1'b1, 32'd1 - m_acc, w);
  endtask

  task automatic ticks(input int n, input logic [7:0] w);
    for (int i = 0; i < n; i++) step(1'b1, 32'd0, w);
  endtask

  // monitor: compares after each edge
  initial begin
    forever begin
      @(posedge clk_i); #2;
      if (exp_q.size() > 0) begin
        logic e; string r;
        e = exp_q.pop_front(); r = req_q.pop_front();
        n_chk++;
        if (pulse_o !== e) begin
          n_bad++;
          $display("FAIL %s pulse_o=%0b expected %0b at %0t", r, pulse_o, e, $time);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog pulse_o=%0b expected completion", pulse_o);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    n_chk++;
    if (pulse_o !== 1'b0) begin
      n_bad++; $display("FAIL R1 reset pulse_o=%0b expected 0", pulse_o);
    end
    rst_ni = 1'b1;
    // R1 R2: from zero, a quarter step carries on the fourth strobe
    cur_req = "R2";
    for (int i = 0; i < 6; i++) step(1'b1, 32'h4000_0000, 8'd2);
    // R6: full-length pulse, width 3 -> 24 strobes high
    cur_req = "R6";
    fire(8'd3); ticks(30, 8'd3);
    fire(8'd1); ticks(10, 8'd1);
    // R8: idle cycles interleaved, nothing moves
    cur_req = "R8";
    fire(8'd2);
    for (int i = 0; i < 20; i++) begin
      step(1'b0, 32'hF000_0001, 8'd9);
      step(1'b0, 32'h8000_0000, 8'd0);
      step(1'b1, 32'd0, 8'd2);
    end
    // R7: width changed mid-pulse is ignored
    cur_req = "R7";
    fire(8'd4); ticks(40, 8'd1);
    // R4: retrigger during a pulse restarts the countdown
    cur_req = "R4";
    step(1'b1, 32'd5, 8'd2);
    fire(8'd2); ticks(10, 8'd2);
    fire(8'd2); ticks(20, 8'd2);
    // R5: zero width gives no pulse
    cur_req = "R5";
    step(1'b1, 32'd5, 8'd0);
    fire(8'd0); ticks(20, 8'd0);
    // R3: blanking mid-pulse, then carry together with bit 31
    cur_req = "R3";
    step(1'b1, 32'd5, 8'd3);
    fire(8'd3); ticks(10, 8'd3);
    step(1'b1, 32'h8000_0000, 8'd3);
    step(1'b1, 32'h8000_0000, 8'd3);
    ticks(5, 8'd3);
    step(1'b1, 32'hC000_0000 - m_acc, 8'd3);
    step(1'b1, 32'hC000_0000, 8'd3);
    ticks(10, 8'd3);
    repeat (4) @(negedge clk_i);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule